// File: doc/BRIEF.md
# Ordered-Decay Power-Off Time Estimator

This block estimates how long a device was without power. It watches a set of SRAM words whose cells all lose a written value at different, previously profiled moments after power is removed. Before shutdown it fills the monitored words with ones. At the next boot it finds how far the decay has advanced and reports that as a count, which later logic turns into elapsed time.

The monitored cells come in groups of `GRP_W` bits, and each group is one SRAM word. A lookup memory outside the block holds the groups in the order in which they decay: index 0 decays first and index `2^IDX_W-1` decays last. Decay is treated as monotonic in that order. Every group below the boundary counts as decayed and every group at or above it counts as intact. The block finds the boundary with a binary search that reads one word per probe. A word is judged by a majority vote over its bits, so a few cells that flip at random cannot move the result.

A quick mode looks only at the last group to decay. It writes that group at shutdown and reads it at boot, and it reports only whether decay is complete. This takes the same short, fixed time on every boot.

Top module: `decay_time_est`

## Requirements
- R1: While `rst_ni` is low, and afterwards until a request arrives, `busy_o`, `done_o`, `full_decay_o`, `sram_re_o` and `sram_we_o` are 0 and `count_o` is 0.
- R2: `init_i` with `quick_i`=0 in idle writes `sram_wdata_o` = all ones once to the word at `lut_addr_i` for each index 0 to `2^IDX_W-1`, in ascending order, one write per cycle. No other address is written. The block then returns to idle.
- R3: `init_i` with `quick_i`=1 in idle writes all ones only to the word of index `2^IDX_W-1`. That is exactly one write.
- R4: A group counts as intact when at least `GRP_W/2` of its bits read 1, and as decayed otherwise. With `GRP_W`=8, a word with 4 ones (8'h0F) is intact and a word with 3 ones (8'h07) is decayed.
- R5: `start_i` with `quick_i`=0 in idle runs the search. When groups with index below c are decayed and the rest are intact, `count_o` becomes c, for any c from 0 to `2^IDX_W`.
- R6: A search makes at most `IDX_W+1` SRAM reads. `done_o` rises within `2*IDX_W+4` clock cycles of the cycle in which `start_i` is sampled.
- R7: `done_o` is high for exactly one cycle per estimate. `count_o` changes only in a cycle in which `done_o` is high.
- R8: `start_i` with `quick_i`=1 in idle reads only the word of index `2^IDX_W-1`, with a single read. It sets `full_decay_o` to that group's decayed verdict, pulses `done_o`, and leaves `count_o` unchanged.
- R9: After a search, `full_decay_o` is 1 exactly when `count_o` equals `2^IDX_W`.
- R10: When `init_i` and `start_i` arrive in the same idle cycle, only the init runs. Any request that arrives while `busy_o` is high is ignored.
- R11: A read and a write are never issued in the same cycle. Writes occur only during init and reads only during an estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an estimate (boot) |
| init_i | input | 1 | Begin writing ones to the monitored words (shutdown) |
| quick_i | input | 1 | Select quick mode for the request sampled with it |
| lut_idx_o | output | IDX_W | Decay-order index looked up |
| lut_addr_i | input | ADDR_W | SRAM address of that group, combinational answer |
| sram_addr_o | output | ADDR_W | SRAM word address |
| sram_re_o | output | 1 | SRAM read strobe; data is returned one cycle later |
| sram_we_o | output | 1 | SRAM write strobe |
| sram_wdata_o | output | GRP_W | SRAM write data |
| sram_rdata_i | input | GRP_W | SRAM read data |
| busy_o | output | 1 | An init or an estimate is in progress |
| done_o | output | 1 | One-cycle pulse at the end of an estimate |
| count_o | output | IDX_W+1 | Number of decayed groups |
| full_decay_o | output | 1 | All monitored groups have decayed |

## Verification
The shutdown fill and the boot search share the SRAM port and the idle state, so two things can collide. A start and an init can arrive in the same idle cycle, and a request can arrive while the other job is still running. The bench raises `start_i` and `init_i` together, and it also raises `init_i` in the middle of a search. It judges both cases at the SRAM model by counting writes, reads and done pulses, and by checking that the interrupted search still returns the right boundary count.

// File: rtl/decay_est_pkg.sv
package decay_est_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_PRB_RD,
    ST_PRB_EV,
    ST_QCK_RD,
    ST_QCK_EV,
    ST_DONE
  } est_state_e;
endpackage

// File: rtl/decay_vote.sv
module decay_vote #(
  parameter int unsigned GRP_W = 8
) (
  input  logic [GRP_W-1:0] word_i,
  output logic             decayed_o
);
  localparam int unsigned CW   = $clog2(GRP_W + 1);
  localparam int unsigned HALF = GRP_W / 2;

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < GRP_W; i++) ones = ones + CW'(word_i[i]);
  end

  // R4: intact needs at least half ones
  assign decayed_o = (ones < CW'(HALF));
endmodule

// File: rtl/bound_search.sv
module bound_search #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             decayed_i,
  output logic [IDX_W:0]   mid_o,
  output logic [IDX_W:0]   lo_o,
  output logic             finished_o
);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] NUM = CNT_W'(1) << IDX_W;

  logic [CNT_W-1:0] lo_q, hi_q;
  logic [CNT_W:0]   sum;

  assign sum        = {1'b0, lo_q} + {1'b0, hi_q};
  assign mid_o      = sum[CNT_W:1];
  assign lo_o       = lo_q;
  assign finished_o = (lo_q == hi_q);

  // lo: groups below are decayed; hi: groups at/above are intact
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (clear_i) begin
      lo_q <= '0;
      hi_q <= NUM;
    end else if (step_i) begin
      if (decayed_i) lo_q <= mid_o + CNT_W'(1);
      else           hi_q <= mid_o;
    end
  end
endmodule

// File: rtl/init_walker.sv
module init_walker #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             last_only_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q;

  assign idx_o  = idx_q;
  assign last_o = (idx_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (load_i)  idx_q <= last_only_i ? '1 : '0;
    else if (step_i)  idx_q <= idx_q + IDX_W'(1);
  end
endmodule

// File: rtl/decay_time_est.sv
module decay_time_est
  import decay_est_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned GRP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              init_i,
  input  logic              quick_i,
  output logic [IDX_W-1:0]  lut_idx_o,
  input  logic [ADDR_W-1:0] lut_addr_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_re_o,
  output logic              sram_we_o,
  output logic [GRP_W-1:0]  sram_wdata_o,
  input  logic [GRP_W-1:0]  sram_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [IDX_W:0]    count_o,
  output logic              full_decay_o
);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] NUM = CNT_W'(1) << IDX_W;

  est_state_e st_q, st_d;

  logic             clear, step, decayed, finished;
  logic             wl_load, wl_step, wl_last;
  logic [IDX_W-1:0] wl_idx;
  logic [IDX_W:0]   mid, lo;
  logic [IDX_W:0]   count_q;
  logic             full_q;

  decay_vote #(.GRP_W(GRP_W)) u_vote (
    .word_i    (sram_rdata_i),
    .decayed_o (decayed)
  );

  bound_search #(.IDX_W(IDX_W)) u_search (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .step_i     (step),
    .decayed_i  (decayed),
    .mid_o      (mid),
    .lo_o       (lo),
    .finished_o (finished)
  );

  init_walker #(.IDX_W(IDX_W)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (wl_load),
    .last_only_i (quick_i),
    .step_i      (wl_step),
    .idx_o       (wl_idx),
    .last_o      (wl_last)
  );

  always_comb begin
    st_d    = st_q;
    clear   = 1'b0;
    step    = 1'b0;
    wl_load = 1'b0;
    wl_step = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        // R10: init wins over start
        if (init_i) begin
          wl_load = 1'b1;
          st_d    = ST_INIT;
        end else if (start_i) begin
          if (quick_i) st_d = ST_QCK_RD;
          else begin
            clear = 1'b1;
            st_d  = ST_PRB_RD;
          end
        end
      end
      ST_INIT: begin
        wl_step = 1'b1;
        if (wl_last) st_d = ST_IDLE;
      end
      ST_PRB_RD: st_d = finished ? ST_DONE : ST_PRB_EV;
      ST_PRB_EV: begin
        step = 1'b1;
        st_d = ST_PRB_RD;
      end
      ST_QCK_RD: st_d = ST_QCK_EV;
      ST_QCK_EV: st_d = ST_DONE;
      ST_DONE:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      full_q  <= 1'b0;
    end else if (st_q == ST_PRB_RD && finished) begin
      count_q <= lo;
      full_q  <= (lo == NUM);
    end else if (st_q == ST_QCK_EV) begin
      full_q  <= decayed;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_INIT:   lut_idx_o = wl_idx;
      ST_PRB_RD: lut_idx_o = mid[IDX_W-1:0];
      default:   lut_idx_o = '1;
    endcase
  end

  assign sram_addr_o  = lut_addr_i;
  assign sram_we_o    = (st_q == ST_INIT);
  assign sram_wdata_o = '1;
  assign sram_re_o    = (st_q == ST_PRB_RD && !finished) || (st_q == ST_QCK_RD);
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_DONE);
  assign count_o      = count_q;
  assign full_decay_o = full_q;
endmodule

// File: rtl/decay_est_chk.sv
module decay_est_chk #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned GRP_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sram_re_o,
  input logic             sram_we_o,
  input logic [GRP_W-1:0] sram_wdata_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [IDX_W:0]   count_o
);
  localparam logic [IDX_W:0] NUM = (IDX_W+1)'(1) << IDX_W;

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_count_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_o) |-> done_o);

  a_r11_no_rw_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_re_o && sram_we_o));

  a_r2_write_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_we_o |-> (sram_wdata_o == '1));

  a_r5_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= NUM);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sram_re_o && !sram_we_o && !done_o));
endmodule

bind decay_time_est decay_est_chk #(.IDX_W(IDX_W), .GRP_W(GRP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sram_re_o    (sram_re_o),
  .sram_we_o    (sram_we_o),
  .sram_wdata_o (sram_wdata_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .count_o      (count_o)
);

// File: tb/tb_decay_time_est.sv
module tb_decay_time_est;
  localparam int IDX_W = 4;
  localparam int ADDR_W = 8;
  localparam int GRP_W = 8;
  localparam int NUM = 1 << IDX_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, init_i = 1'b0, quick_i = 1'b0;
  logic [IDX_W-1:0] lut_idx_o;
  logic [ADDR_W-1:0] lut_addr_i, sram_addr_o;
  logic sram_re_o, sram_we_o, busy_o, done_o, full_decay_o;
  logic [GRP_W-1:0] sram_wdata_o, sram_rdata_i;
  logic [IDX_W:0] count_o;

  always #2 clk_i = ~clk_i;

  decay_time_est #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .GRP_W(GRP_W)) dut (.*);

  function automatic logic [ADDR_W-1:0] lut_map(input int idx);
    return ADDR_W'(idx * 37 + 11);
  endfunction
  assign lut_addr_i = lut_map(int'(lut_idx_o));

  logic [GRP_W-1:0] mem [DEPTH];
  logic [GRP_W-1:0] pre [DEPTH];
  logic pre_go = 1'b0, clr_cnt = 1'b0;
  int wr_cnt, rd_cnt, done_cnt;

  always @(posedge clk_i) begin
    if (pre_go) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= pre[i];
    end else if (sram_we_o) mem[sram_addr_o] <= sram_wdata_o;
    if (sram_re_o) sram_rdata_i <= mem[sram_addr_o];
    if (clr_cnt) begin
      wr_cnt <= 0; rd_cnt <= 0; done_cnt <= 0;
    end else begin
      wr_cnt   <= wr_cnt + int'(sram_we_o);
      rd_cnt   <= rd_cnt + int'(sram_re_o);
      done_cnt <= done_cnt + int'(done_o);
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic preload(input int c, input logic [7:0] dpat, input logic [7:0] ipat);
    for (int i = 0; i < DEPTH; i++) pre[i] = 8'h00;
    for (int g = 0; g < NUM; g++) pre[lut_map(g)] = (g < c) ? dpat : ipat;
    @(negedge clk_i); pre_go = 1'b1; clr_cnt = 1'b1;
    @(negedge clk_i); pre_go = 1'b0; clr_cnt = 1'b0;
  endtask

  // returns cycles from start to done (0 if none)
  task automatic request(input bit st, input bit in, input bit q, output int cyc);
    start_i = st; init_i = in; quick_i = q;
    cyc = 0;
    @(negedge clk_i);
    start_i = 1'b0; init_i = 1'b0; quick_i = 1'b0;
    for (int k = 1; k <= 60; k++) begin
      if (done_o && cyc == 0) cyc = k;
      if (!busy_o) break;
      @(negedge clk_i);
    end
    @(negedge clk_i);
  endtask

  typedef logic [20:0] vec_t; // {count, decayed pattern, intact pattern}
  localparam vec_t VEC [10] = '{
    {5'd0,  8'h00, 8'hFF}, {5'd16, 8'h00, 8'hFF}, {5'd1,  8'h07, 8'h0F},
    {5'd15, 8'h03, 8'hF0}, {5'd8,  8'h00, 8'hFF}, {5'd5,  8'hE0, 8'h1E},
    {5'd3,  8'h01, 8'hFF}, {5'd12, 8'h80, 8'h33}, {5'd11, 8'h70, 8'hAA},
    {5'd2,  8'h15, 8'h78}
  };

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc, prev;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && count_o == 0 && !full_decay_o && !sram_re_o && !sram_we_o,
          "R1 in reset", int'(busy_o | done_o | sram_re_o | sram_we_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!busy_o && count_o == 0 && !sram_re_o && !sram_we_o, "R1 after reset",
          int'(count_o), 0);

    // R5 R6 R7 R9 R4: vector table
    foreach (VEC[v]) begin
      int c;
      c = int'(VEC[v][20:16]);
      preload(c, VEC[v][15:8], VEC[v][7:0]);
      request(1'b1, 1'b0, 1'b0, cyc);
      check(int'(count_o) == c, "R5 count", int'(count_o), c);
      check(full_decay_o == (c == NUM), "R9 full flag", int'(full_decay_o), int'(c == NUM));
      check(rd_cnt <= IDX_W + 1, "R6 reads", rd_cnt, IDX_W + 1);
      check(cyc > 0 && cyc <= 2 * IDX_W + 4, "R6 latency", cyc, 2 * IDX_W + 4);
      check(done_cnt == 1, "R7 one done pulse", done_cnt, 1);
      check(wr_cnt == 0, "R11 no write in estimate", wr_cnt, 0);
    end

    // R2 full init
    preload(0, 8'h00, 8'h00);
    request(1'b0, 1'b1, 1'b0, cyc);
    check(wr_cnt == NUM, "R2 write count", wr_cnt, NUM);
    for (int g = 0; g < NUM; g++)
      check(mem[lut_map(g)] == 8'hFF, "R2 group filled", int'(mem[lut_map(g)]), 255);
    check(mem[12] == 8'h00, "R2 other address untouched", int'(mem[12]), 0);
    check(rd_cnt == 0 && cyc == 0, "R11 no read in init", rd_cnt, 0);

    // R3 quick init
    preload(0, 8'h00, 8'h00);
    request(1'b0, 1'b1, 1'b1, cyc);
    check(wr_cnt == 1, "R3 write count", wr_cnt, 1);
    check(mem[lut_map(NUM-1)] == 8'hFF, "R3 last group", int'(mem[lut_map(NUM-1)]), 255);
    check(mem[lut_map(0)] == 8'h00, "R3 first group untouched", int'(mem[lut_map(0)]), 0);

    // R8 quick check: last group decayed (3 ones)
    preload(6, 8'h00, 8'hFF);
    request(1'b1, 1'b0, 1'b0, cyc);
    prev = int'(count_o);
    preload(NUM, 8'h07, 8'hFF);
    request(1'b1, 1'b0, 1'b1, cyc);
    check(full_decay_o == 1'b1, "R8 full decay", int'(full_decay_o), 1);
    check(rd_cnt == 1 && done_cnt == 1, "R8 single read", rd_cnt, 1);
    check(int'(count_o) == prev, "R8 count unchanged", int'(count_o), prev);
    // R8 R4: last group intact with exactly half ones
    preload(NUM - 1, 8'h00, 8'h0F);
    request(1'b1, 1'b0, 1'b1, cyc);
    check(full_decay_o == 1'b0, "R8 R4 not full", int'(full_decay_o), 0);

    // R10 same-cycle start and init
    preload(4, 8'h00, 8'h00);
    request(1'b1, 1'b1, 1'b0, cyc);
    check(wr_cnt == NUM, "R10 init ran", wr_cnt, NUM);
    check(rd_cnt == 0 && done_cnt == 0, "R10 start dropped", rd_cnt + done_cnt, 0);

    // R10 init during search is ignored
    preload(6, 8'h00, 8'hFF);
    start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    @(negedge clk_i); init_i = 1'b1;
    @(negedge clk_i); init_i = 1'b0;
    repeat (20) @(negedge clk_i);
    check(int'(count_o) == 6, "R10 search result kept", int'(count_o), 6);
    check(wr_cnt == 0, "R10 busy init ignored", wr_cnt, 0);
    check(!busy_o, "R10 back to idle", int'(busy_o), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule